// File: doc/BRIEF.md
# Second-Stage Erasure Flag Decision Unit

This block sits behind the syndrome and error-locator logic of a two-stage Reed-Solomon decoder. For each codeword it receives three things: an error-count class, up to two computed error positions, and the reliability flags produced by the first decoding stage. From these it decides whether a correction may be applied and which reliability flags go out with the codeword. The syndrome arithmetic itself is done elsewhere; this unit only applies the decision rules.

The unit has two modes. In second-stage mode, the choice between correcting, forcing every flag on, or handing the incoming flags through unchanged depends on two things: how many first-stage flags are set, and whether the computed error positions land on flagged symbols. In first-stage mode, the error class alone chooses the action. A start pulse captures one codeword's inputs. The unit then walks the flag vector one symbol per clock, counting flags and testing the positions. It ends with a one-cycle done pulse that carries a registered decision.

Top module: `c2_flag_decider`

## Requirements
- R1: While reset is low and after it is released, `done`, `busy` and `corr_num` are 0 and `flags_out` is all zeros.
- R2: A `start` accepted at a clock edge gives `done` high for exactly one cycle, NSYM+1 clock edges later (29 with NSYM=28). `busy` is high from the edge after the accepted start up to, but not including, the `done` cycle.
- R3: With `mode`=0 (first-stage rule), the error class (`err_cls`: 0 none, 1 one, 2 two, 3 three or more) alone selects the result. Class 0 gives no correction and all flags 0. Class 1 gives a correction of 1 symbol and all flags 0. Class 2 gives a correction of 2 symbols and all flags 1. Class 3 gives no correction and all flags 1.
- R4: With `mode`=1, class 0 gives no correction and zero flags. Class 1 gives a correction of one symbol at `pos_a` and zero flags. `corr_num` reports 0, 1 or 2 symbols, and `corr_pos_a`/`corr_pos_b` carry the captured positions.
- R5: With `mode`=1 and class 2, if both positions hit set input flags: when fewer than 7 input flags are set, correct both symbols and clear all flags; when 7 or more are set, do not correct and pass the input flags through.
- R6: With `mode`=1 and class 2, if exactly one position hits a set flag: never correct. Force all flags to 1 when 5 or fewer input flags are set, and pass the input flags through when 6 or more are set.
- R7: With `mode`=1 and class 2, if neither position hits a set flag: never correct. Force all flags to 1 when 2 or fewer input flags are set, and pass the input flags through otherwise.
- R8: With `mode`=1 and class 3: never correct. Force all flags to 1 when 2 or fewer input flags are set, and pass the input flags through otherwise.
- R9: A position counts as hitting a flag only when it is below NSYM and the input flag bit at that index is 1. Position values 28 to 31 never hit.
- R10: A `start` that arrives while `busy` is high is ignored. The decision then reported is the one for the inputs captured first.
- R11: A `start` in the same cycle as `done` is accepted. Between two done pulses the decision outputs hold the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture inputs and begin a decision |
| mode | input | 1 | 0 first-stage rule, 1 second-stage rule |
| err_cls | input | 2 | Error class: 0 none, 1 one, 2 two, 3 three or more |
| pos_a | input | 5 | First computed error position |
| pos_b | input | 5 | Second computed error position |
| flags_in | input | 28 | First-stage per-symbol flags |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: decision outputs updated |
| corr_num | output | 2 | Symbols to correct: 0, 1 or 2 |
| corr_pos_a | output | 5 | First position to correct |
| corr_pos_b | output | 5 | Second position to correct |
| flags_out | output | 28 | Emitted per-symbol flags |

## Verification
The done pulse for one codeword and the acceptance of the next codeword's start fall in the same cycle. The bench provokes this by driving every new start at the very edge where the previous done is seen. It then judges two things: that the second result arrives after exactly 29 edges, and that the first result's flags stay visible on the outputs in the middle of the second scan. A start injected mid-scan with different inputs checks that an in-flight decision is not disturbed. Directed vectors place the flag count on each side of the 2/3, 5/6 and 6/7 thresholds. Randomized vectors are biased so that their positions often land on flagged symbols.

// File: rtl/cfd_pkg.sv
// Package: shared types and rule thresholds for the erasure flag decision unit.
// Assumes the error class encoding is fixed by the upstream syndrome stage.
package cfd_pkg;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_ONE  = 2'd1,
        ERR_TWO  = 2'd2,
        ERR_MANY = 2'd3
    } err_cls_t;

    localparam logic MODE_FIRST  = 1'b0;
    localparam logic MODE_SECOND = 1'b1;

    // Flag-count thresholds used by the second-stage rule.
    localparam int TH_BOTH_PASS = 7;  // both hit: pass at or above this count
    localparam int TH_ONE_PASS  = 6;  // one hit: pass at or above this count
    localparam int TH_LOW_SET   = 2;  // no hit / many errors: force at or below

endpackage

// File: rtl/cfd_scan.sv
// Module: sequential flag scanner.
// Walks the captured flag vector one symbol per clock after a go pulse.
// It counts set flags and records whether each position lands on a set flag.
// Assumes inputs stay stable while active. Raises fin for one cycle after the last symbol.
module cfd_scan #(
    parameter int NSYM  = 28,
    parameter int IDX_W = $clog2(NSYM),
    parameter int CNT_W = $clog2(NSYM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NSYM-1:0]  flags,
    input  logic [IDX_W-1:0] pos_a,
    input  logic [IDX_W-1:0] pos_b,
    output logic             active,
    output logic             fin,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_a,
    output logic             hit_b
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSYM - 1);

    logic [IDX_W-1:0] idx;
    logic             cur_bit;

    // Select the flag bit under the scan pointer.
    always_comb begin
        cur_bit = flags[idx];
    end

    // Advance the scan pointer, accumulate the count and record position hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
            cnt    <= '0;
            hit_a  <= 1'b0;
            hit_b  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                idx    <= '0;
                active <= 1'b1;
                cnt    <= '0;
                hit_a  <= 1'b0;
                hit_b  <= 1'b0;
            end else if (active) begin
                cnt <= cnt + CNT_W'(cur_bit);
                if (idx == pos_a) hit_a <= cur_bit;
                if (idx == pos_b) hit_b <= cur_bit;
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R2: the pointer never leaves the codeword while scanning
    assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx <= LAST_IDX));

    // R2: the running count never exceeds the number of symbols visited
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (CNT_W'(idx) >= cnt));

    // R2: completion is a single-cycle pulse
    assert_fin_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/cfd_rule.sv
// Module: combinational decision table.
// Maps mode, error class, flag count and position hits to a correction count and an output flag vector.
// Assumes cnt and hits are final, i.e. sampled when the scanner reports completion.
module cfd_rule #(
    parameter int NSYM  = 28,
    parameter int CNT_W = $clog2(NSYM + 1)
) (
    input  logic             mode,
    input  logic [1:0]       err_cls,
    input  logic [CNT_W-1:0] cnt,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic [NSYM-1:0]  flags,
    output logic [1:0]       corr_num,
    output logic [NSYM-1:0]  flags_next
);
    import cfd_pkg::*;

    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_FORCE = 2'd1,
        ACT_PASS  = 2'd2
    } flag_act_t;

    err_cls_t  cls;
    flag_act_t act;
    logic      few_low;
    logic      few_one;
    logic      few_both;

    // Threshold comparisons on the scanned count.
    always_comb begin
        few_low  = (cnt <= CNT_W'(TH_LOW_SET));
        few_one  = (cnt <  CNT_W'(TH_ONE_PASS));
        few_both = (cnt <  CNT_W'(TH_BOTH_PASS));
    end

    // Pick the correction count and flag action from the rule table.
    always_comb begin
        cls      = err_cls_t'(err_cls);
        corr_num = 2'd0;
        act      = ACT_CLEAR;
        if (mode == MODE_FIRST) begin
            unique case (cls)
                ERR_NONE: begin corr_num = 2'd0; act = ACT_CLEAR; end
                ERR_ONE:  begin corr_num = 2'd1; act = ACT_CLEAR; end
                ERR_TWO:  begin corr_num = 2'd2; act = ACT_FORCE; end
                default:  begin corr_num = 2'd0; act = ACT_FORCE; end
            endcase
        end else begin
            unique case (cls)
                ERR_NONE: begin corr_num = 2'd0; act = ACT_CLEAR; end
                ERR_ONE:  begin corr_num = 2'd1; act = ACT_CLEAR; end
                ERR_TWO: begin
                    if (hit_a && hit_b) begin
                        corr_num = few_both ? 2'd2 : 2'd0;
                        act      = few_both ? ACT_CLEAR : ACT_PASS;
                    end else if (hit_a || hit_b) begin
                        act = few_one ? ACT_FORCE : ACT_PASS;
                    end else begin
                        act = few_low ? ACT_FORCE : ACT_PASS;
                    end
                end
                default: act = few_low ? ACT_FORCE : ACT_PASS;
            endcase
        end
    end

    // Expand the chosen action into the full flag vector.
    always_comb begin
        unique case (act)
            ACT_FORCE: flags_next = '1;
            ACT_PASS:  flags_next = flags;
            default:   flags_next = '0;
        endcase
    end

endmodule

// File: rtl/c2_flag_decider.sv
// Module: top of the erasure flag decision unit.
// Captures a codeword's inputs on an accepted start and runs the scanner.
// When the scan finishes it registers the rule output and pulses done.
// Assumes start is ignored while busy. Outputs hold between done pulses.
module c2_flag_decider #(
    parameter int NSYM  = 28,
    parameter int POS_W = $clog2(NSYM),
    parameter int CNT_W = $clog2(NSYM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [1:0]       err_cls,
    input  logic [POS_W-1:0] pos_a,
    input  logic [POS_W-1:0] pos_b,
    input  logic [NSYM-1:0]  flags_in,
    output logic             busy,
    output logic             done,
    output logic [1:0]       corr_num,
    output logic [POS_W-1:0] corr_pos_a,
    output logic [POS_W-1:0] corr_pos_b,
    output logic [NSYM-1:0]  flags_out
);

    logic             accept;
    logic             mode_q;
    logic [1:0]       cls_q;
    logic [POS_W-1:0] pa_q;
    logic [POS_W-1:0] pb_q;
    logic [NSYM-1:0]  flags_q;
    logic             scan_active;
    logic             scan_fin;
    logic [CNT_W-1:0] scan_cnt;
    logic             scan_hit_a;
    logic             scan_hit_b;
    logic [1:0]       rule_corr;
    logic [NSYM-1:0]  rule_flags;

    // Busy spans the scan and the completion cycle; start is accepted only when idle.
    always_comb begin
        busy   = scan_active | scan_fin;
        accept = start & ~busy;
    end

    // Capture the codeword inputs on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            cls_q   <= 2'd0;
            pa_q    <= '0;
            pb_q    <= '0;
            flags_q <= '0;
        end else if (accept) begin
            mode_q  <= mode;
            cls_q   <= err_cls;
            pa_q    <= pos_a;
            pb_q    <= pos_b;
            flags_q <= flags_in;
        end
    end

    cfd_scan #(.NSYM(NSYM), .IDX_W(POS_W), .CNT_W(CNT_W)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (accept),
        .flags  (flags_q),
        .pos_a  (pa_q),
        .pos_b  (pb_q),
        .active (scan_active),
        .fin    (scan_fin),
        .cnt    (scan_cnt),
        .hit_a  (scan_hit_a),
        .hit_b  (scan_hit_b)
    );

    cfd_rule #(.NSYM(NSYM), .CNT_W(CNT_W)) u_rule (
        .mode       (mode_q),
        .err_cls    (cls_q),
        .cnt        (scan_cnt),
        .hit_a      (scan_hit_a),
        .hit_b      (scan_hit_b),
        .flags      (flags_q),
        .corr_num   (rule_corr),
        .flags_next (rule_flags)
    );

    // Register the decision when the scan completes; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            corr_num   <= 2'd0;
            corr_pos_a <= '0;
            corr_pos_b <= '0;
            flags_out  <= '0;
        end else begin
            done <= scan_fin;
            if (scan_fin) begin
                corr_num   <= rule_corr;
                corr_pos_a <= pa_q;
                corr_pos_b <= pb_q;
                flags_out  <= rule_flags;
            end
        end
    end

    // R2: the decision lands the cycle after the scanner completes
    assert_done_after_fin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_fin |=> done);

    // R2: done is a single-cycle pulse
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a start during a scan leaves the captured inputs untouched
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(flags_q) && $stable(pa_q) && $stable(pb_q) && $stable(cls_q)));

    // R11: decision outputs change only on a done pulse
    assert_hold_between_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_fin |=> ($stable(flags_out) && $stable(corr_num)));

    // R5: in the second-stage rule, any correction comes with cleared flags
    assert_corr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q && corr_num != 2'd0) |-> (flags_out == '0));

endmodule

// File: tb/sim_c2_flag_decider.sv
module sim_c2_flag_decider;

    localparam int NSYM = 28;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        mode;
    logic [1:0]  err_cls;
    logic [4:0]  pos_a;
    logic [4:0]  pos_b;
    logic [27:0] flags_in;
    logic        busy;
    logic        done;
    logic [1:0]  corr_num;
    logic [4:0]  corr_pos_a;
    logic [4:0]  corr_pos_b;
    logic [27:0] flags_out;

    int          vectors = 0;
    int          miscompares = 0;
    logic [27:0] prev_flags = '0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    c2_flag_decider #(.NSYM(NSYM)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .err_cls    (err_cls),
        .pos_a      (pos_a),
        .pos_b      (pos_b),
        .flags_in   (flags_in),
        .busy       (busy),
        .done       (done),
        .corr_num   (corr_num),
        .corr_pos_a (corr_pos_a),
        .corr_pos_b (corr_pos_b),
        .flags_out  (flags_out)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void ref_model(input logic m, input logic [1:0] c,
                                      input logic [4:0] pa, input logic [4:0] pb,
                                      input logic [27:0] f, output logic [1:0] en,
                                      output logic [27:0] fo, output string tag);
        int n;
        bit ha;
        bit hb;
        n  = $countones(f);
        ha = (pa < NSYM) ? f[pa] : 1'b0;
        hb = (pb < NSYM) ? f[pb] : 1'b0;
        en = 2'd0;
        fo = '0;
        if (!m) begin
            tag = "R3";
            case (c)
                2'd0: begin en = 0; fo = '0; end
                2'd1: begin en = 1; fo = '0; end
                2'd2: begin en = 2; fo = '1; end
                default: begin en = 0; fo = '1; end
            endcase
        end else if (c == 2'd0) begin
            tag = "R4"; en = 0; fo = '0;
        end else if (c == 2'd1) begin
            tag = "R4"; en = 1; fo = '0;
        end else if (c == 2'd2) begin
            if (ha && hb) begin
                tag = "R5";
                if (n >= 7) begin en = 0; fo = f; end
                else begin en = 2; fo = '0; end
            end else if (ha || hb) begin
                tag = "R6";
                fo = (n <= 5) ? '1 : f;
            end else begin
                tag = "R7";
                fo = (n <= 2) ? '1 : f;
            end
        end else begin
            tag = "R8";
            fo = (n <= 2) ? '1 : f;
        end
    endfunction

    // Issue one codeword at a negedge, wait for done, compare. Returns at the done negedge.
    task automatic apply(input logic m, input logic [1:0] c, input logic [4:0] pa,
                         input logic [4:0] pb, input logic [27:0] f, input bit disturb);
        logic [1:0]  en;
        logic [27:0] fo;
        string       tag;
        int          k;
        ref_model(m, c, pa, pb, f, en, fo, tag);
        mode = m; err_cls = c; pos_a = pa; pos_b = pb; flags_in = f; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 100) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (k == 1) check("R2", "busy during scan", 32'(busy), 32'd1);
            if (k == 10) check("R11", "flags held mid-scan", 32'(flags_out), 32'(prev_flags));
            if (disturb && k == 5) begin
                // R10: foreign start while busy
                start = 1'b1; mode = ~m; err_cls = ~c; pos_a = ~pa; pos_b = ~pb; flags_in = ~f;
            end
            if (disturb && k == 6) start = 1'b0;
        end
        check("R2", "done latency", 32'(k), 32'(NSYM + 1));
        check("R2", "busy low at done", 32'(busy), 32'd0);
        check(tag, "corr_num", 32'(corr_num), 32'(en));
        if (en != 0) check(tag, "corr_pos_a", 32'(corr_pos_a), 32'(pa));
        if (en == 2) check(tag, "corr_pos_b", 32'(corr_pos_b), 32'(pb));
        check(tag, "flags_out", 32'(flags_out), 32'(fo));
        if (disturb) check("R10", "result after ignored start", 32'(flags_out), 32'(fo));
        prev_flags = fo;
    endtask

    function automatic logic [27:0] low_flags(input int n);
        logic [27:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = 1'b1;
        return r;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [27:0] f;
        logic [4:0]  pa;
        logic [4:0]  pb;
        int          nset;
        void'($urandom(20250611));
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; err_cls = 2'd0;
        pos_a = '0; pos_b = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        check("R1", "done in reset", 32'(done), 32'd0);
        check("R1", "busy in reset", 32'(busy), 32'd0);
        check("R1", "corr_num in reset", 32'(corr_num), 32'd0);
        check("R1", "flags_out in reset", 32'(flags_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", 32'({busy, done}), 32'd0);

        // R3: first-stage rule, all four classes
        for (int c = 0; c < 4; c++) apply(1'b0, 2'(c), 5'd3, 5'd9, low_flags(4), 1'b0);
        // R4: second-stage zero and one errors
        apply(1'b1, 2'd0, 5'd1, 5'd2, low_flags(9), 1'b0);
        apply(1'b1, 2'd1, 5'd7, 5'd2, low_flags(9), 1'b0);
        // R5: both hit, count 6 then 7
        apply(1'b1, 2'd2, 5'd0, 5'd1, low_flags(6), 1'b0);
        apply(1'b1, 2'd2, 5'd0, 5'd1, low_flags(7), 1'b0);
        // R6: one hit, count 5 then 6
        apply(1'b1, 2'd2, 5'd0, 5'd27, low_flags(5), 1'b0);
        apply(1'b1, 2'd2, 5'd27, 5'd0, low_flags(6), 1'b0);
        // R7: no hit, count 2 then 3
        apply(1'b1, 2'd2, 5'd26, 5'd27, low_flags(2), 1'b0);
        apply(1'b1, 2'd2, 5'd26, 5'd27, low_flags(3), 1'b0);
        // R8: many errors, count 2 then 3
        apply(1'b1, 2'd3, 5'd0, 5'd1, low_flags(2), 1'b0);
        apply(1'b1, 2'd3, 5'd0, 5'd1, low_flags(3), 1'b0);
        // R9: out-of-range positions never hit
        apply(1'b1, 2'd2, 5'd30, 5'd31, low_flags(3), 1'b0);
        apply(1'b1, 2'd2, 5'd28, 5'd0, 28'h8000001, 1'b0);
        // R10: start while busy ignored
        apply(1'b1, 2'd2, 5'd0, 5'd1, low_flags(4), 1'b1);

        // Randomized vectors, positions biased onto flagged symbols
        for (int v = 0; v < 300; v++) begin
            nset = $urandom_range(0, 10);
            f = '0;
            for (int j = 0; j < nset; j++) f[$urandom_range(0, 27)] = 1'b1;
            pa = 5'($urandom_range(0, 31));
            pb = 5'($urandom_range(0, 31));
            if (f != '0) begin
                for (int t = 0; t < 40; t++) begin
                    if ($urandom_range(0, 2) != 0 && !(pa < NSYM && f[pa])) pa = 5'($urandom_range(0, 27));
                end
                for (int t = 0; t < 40; t++) begin
                    if ($urandom_range(0, 2) == 0 && !(pb < NSYM && f[pb])) pb = 5'($urandom_range(0, 27));
                end
            end
            apply(1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)), pa, pb, f,
                  ($urandom_range(0, 15) == 0));
        end
        summary();
    end

endmodule